// File: doc/BRIEF.md
# Latch-Switched CHR Bank Mapper

This block turns a 13-bit pattern-table fetch address from the picture processor into a CHR ROM address. Eight 16-bit bank registers are loaded one byte at a time from the CPU write bus. A two-bit mode input splits the 8 KiB pattern window into one, two, four or eight equal slots. Each slot takes its bank number from one of the registers. Before that number is used, an outer-bank stage can clip the register value to the width the mode allows and put two outer select bits above it.

In the two-slot (4 KiB) mode, neither half has a fixed register. Each half reads the register named by a small latch. The block updates these latches by watching the picture processor's own fetches: a fetch of certain marker tile rows switches the latch for the half that holds them. A board strap turns this watching on or off. The ROM address follows the fetch address with no register in the path. Register writes and latch switches take effect from the next clock edge.

Top module: `chr_latch_mapper`

## Requirements
- R1: A CPU write with address bits 15..12 equal to 0x9 replaces bits 7..0 of bank register number cpu_addr[2:0]. The other byte and the other registers are kept.
- R2: A CPU write with address bits 15..12 equal to 0xA replaces bits 15..8 of bank register number cpu_addr[2:0]. The other byte and the other registers are kept.
- R3: After reset, every bank register holds 0xFFFF. The lower-half latch holds 0 and the upper-half latch holds 4.
- R4: With chr_mode = 0 (one 8 KiB slot), the address is bank(reg0) × 8192 + ppu_addr[12:0].
- R5: With chr_mode = 2 (four 2 KiB slots), slot k = ppu_addr[12:11] uses register 2k. The address is bank × 2048 + ppu_addr[10:0].
- R6: With chr_mode = 3 (eight 1 KiB slots), slot k = ppu_addr[12:10] uses register k. The address is bank × 1024 + ppu_addr[9:0].
- R7: With chr_mode = 1 (two 4 KiB halves), the half picked by ppu_addr[12] uses the register named by that half's latch. The address is bank × 4096 + ppu_addr[11:0].
- R8: When snoop_en = 1, a fetch (ppu_rd = 1) with ppu_addr[13] = 0 and ppu_addr[11:3] equal to 0x1FB (rows 0xFD8..0xFDF) or 0x1FD (rows 0xFE8..0xFEF) sets a latch. The latch is the lower one if ppu_addr[12] = 0 and the upper one if ppu_addr[12] = 1. The lower latch becomes 0 or 2 and the upper latch becomes 4 or 6, for the first and second row respectively. Any other fetch leaves both latches unchanged.
- R9: When snoop_en = 0, the latches never change. While snoop_en = 1, the latches also follow fetches in modes other than 4 KiB, and the state they reach is used when the 4 KiB mode is next selected.
- R10: With outer_off = 1, the bank number is the full 16-bit register value, and outer_sel has no effect.
- R11: With outer_off = 0, let s = 5 + chr_mode. The bank number is (register mod 2^s) + outer_sel × 2^s.
- R12: CPU writes whose bits 15..12 are neither 0x9 nor 0xA leave every bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| chr_mode | input | 2 | Slot split: 0 = 8K, 1 = 4K latched, 2 = 2K, 3 = 1K |
| outer_off | input | 1 | 1 disables the outer-bank clip and offset |
| outer_sel | input | 2 | Outer CHR bank select bits |
| snoop_en | input | 1 | Board strap that enables latch snooping |
| ppu_rd | input | 1 | Pattern fetch strobe |
| ppu_addr | input | 14 | Picture processor fetch address |
| chr_rom_addr | output | 29 | Mapped CHR ROM byte address |

## Verification
The ROM address is combinational in ppu_addr, chr_mode, outer_off and outer_sel. The bench changes those inputs between clock edges and samples one time unit later, with no clock edge in between. A register byte write or a latch-switching fetch is presented at a falling edge, lands at the following rising edge, and is visible from the next falling edge on. So every write or fetch is followed by at least one whole cycle before any lookup depends on it. The bench sweeps all four modes, both outer settings and each outer select value over every 1 KiB slot. It compares each result with an address computed from the bench's own copy of the registers and latches.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

  localparam int SLOT_CNT   = 8;
  localparam int SLOT_IDX_W = 3;
  localparam int PPU_AW     = 14;

  typedef enum logic [1:0] {
    CM_8K = 2'd0,
    CM_4K = 2'd1,
    CM_2K = 2'd2,
    CM_1K = 2'd3
  } chr_mode_e;

  // Marker rows 0xFD8..0xFDF and 0xFE8..0xFEF inside the pattern space.
  function automatic logic snoop_hit(input logic [PPU_AW-1:0] a);
    return (a[13] == 1'b0) && ((a[11:3] == 9'h1FB) || (a[11:3] == 9'h1FD));
  endfunction

  // Latch value: bit1 picks the second marker row, bit2 the upper half.
  function automatic logic [SLOT_IDX_W-1:0] snoop_val(input logic [PPU_AW-1:0] a);
    return {a[12] & a[6], a[5], 1'b0};
  endfunction

endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_map_pkg::*;
#(
  parameter int BANK_W = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [15:0]                        addr,
  input  logic [7:0]                         wdata,
  output logic [SLOT_CNT-1:0][BANK_W-1:0]    bank_q
);

  localparam int LO_W = 8;
  localparam int HI_W = BANK_W - LO_W;

  logic                  lo_hit;
  logic                  hi_hit;
  logic [SLOT_IDX_W-1:0] idx;
  logic                  unused_addr_bits;

  assign lo_hit = we && (addr[15:12] == 4'h9);
  assign hi_hit = we && (addr[15:12] == 4'hA);
  assign idx    = addr[SLOT_IDX_W-1:0];
  assign unused_addr_bits = ^addr[11:SLOT_IDX_W];

  for (genvar g = 0; g < SLOT_CNT; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[g] <= '1;
      end else begin
        if (lo_hit && (idx == SLOT_IDX_W'(g)))
          bank_q[g][LO_W-1:0] <= wdata;
        if (hi_hit && (idx == SLOT_IDX_W'(g)))
          bank_q[g][BANK_W-1:LO_W] <= wdata[HI_W-1:0];
      end
    end
  end

  a_r1_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    lo_hit |=> bank_q[$past(idx)][LO_W-1:0] == $past(wdata));

  a_r2_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
    hi_hit |=> bank_q[$past(idx)][BANK_W-1:LO_W] == $past(wdata[HI_W-1:0]));

  a_r12_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_hit || hi_hit) |=> $stable(bank_q));

endmodule

// File: rtl/chr_latch_snoop.sv
module chr_latch_snoop
  import chr_map_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  snoop_en,
  input  logic                  ppu_rd,
  input  logic [PPU_AW-1:0]     ppu_addr,
  output logic [SLOT_IDX_W-1:0] latch_lo,
  output logic [SLOT_IDX_W-1:0] latch_hi
);

  logic                  take;
  logic [SLOT_IDX_W-1:0] new_val;

  assign take    = snoop_en && ppu_rd && snoop_hit(ppu_addr);
  assign new_val = snoop_val(ppu_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_lo <= SLOT_IDX_W'(0);
      latch_hi <= SLOT_IDX_W'(4);
    end else if (take) begin
      if (ppu_addr[12]) latch_hi <= new_val;
      else              latch_lo <= new_val;
    end
  end

  a_r8_lo_range: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_lo == 3'd0) || (latch_lo == 3'd2));

  a_r8_hi_range: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_hi == 3'd4) || (latch_hi == 3'd6));

  a_r8_take_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ppu_addr[12]) |=> (latch_lo == $past(new_val)) && $stable(latch_hi));

  a_r9_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_en |=> $stable(latch_lo) && $stable(latch_hi));

endmodule

// File: rtl/chr_outer_bank.sv
module chr_outer_bank
  import chr_map_pkg::*;
#(
  parameter int BANK_W     = 16,
  parameter int OUTER_W    = 2,
  parameter int BASE_SHIFT = 5
) (
  input  chr_mode_e          mode,
  input  logic               outer_off,
  input  logic [OUTER_W-1:0] outer_sel,
  output logic [BANK_W-1:0]  mask,
  output logic [BANK_W-1:0]  base
);

  int shamt;

  always_comb begin
    shamt = BASE_SHIFT + int'(mode);
    if (outer_off) begin
      mask = '1;
      base = '0;
    end else begin
      mask = ~({BANK_W{1'b1}} << shamt);
      base = BANK_W'(outer_sel) << shamt;
    end
  end

endmodule

// File: rtl/chr_addr_mux.sv
module chr_addr_mux
  import chr_map_pkg::*;
#(
  parameter int BANK_W = 16
) (
  input  logic [SLOT_CNT-1:0][BANK_W-1:0] bank_q,
  input  logic [SLOT_IDX_W-1:0]           latch_lo,
  input  logic [SLOT_IDX_W-1:0]           latch_hi,
  input  chr_mode_e                       mode,
  input  logic [BANK_W-1:0]               mask,
  input  logic [BANK_W-1:0]               base,
  input  logic [12:0]                     pat_addr,
  output logic [SLOT_IDX_W-1:0]           slot_idx,
  output logic [BANK_W-1:0]               slot_bank,
  output logic [BANK_W+12:0]              rom_addr
);

  always_comb begin
    unique case (mode)
      CM_8K:   slot_idx = '0;
      CM_4K:   slot_idx = pat_addr[12] ? latch_hi : latch_lo;
      CM_2K:   slot_idx = {pat_addr[12:11], 1'b0};
      default: slot_idx = pat_addr[12:10];
    endcase
  end

  assign slot_bank = (bank_q[slot_idx] & mask) | base;

  always_comb begin
    unique case (mode)
      CM_8K:   rom_addr = {slot_bank, pat_addr[12:0]};
      CM_4K:   rom_addr = {1'b0, slot_bank, pat_addr[11:0]};
      CM_2K:   rom_addr = {2'b0, slot_bank, pat_addr[10:0]};
      default: rom_addr = {3'b0, slot_bank, pat_addr[9:0]};
    endcase
  end

endmodule

// File: rtl/chr_latch_mapper.sv
module chr_latch_mapper
  import chr_map_pkg::*;
#(
  parameter int BANK_W     = 16,
  parameter int OUTER_W    = 2,
  parameter int BASE_SHIFT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_we,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic [1:0]         chr_mode,
  input  logic               outer_off,
  input  logic [OUTER_W-1:0] outer_sel,
  input  logic               snoop_en,
  input  logic               ppu_rd,
  input  logic [13:0]        ppu_addr,
  output logic [BANK_W+12:0] chr_rom_addr
);

  logic [SLOT_CNT-1:0][BANK_W-1:0] bank_q;
  logic [SLOT_IDX_W-1:0]           latch_lo;
  logic [SLOT_IDX_W-1:0]           latch_hi;
  logic [BANK_W-1:0]               mask;
  logic [BANK_W-1:0]               base;
  logic [SLOT_IDX_W-1:0]           slot_idx;
  logic [BANK_W-1:0]               slot_bank;
  chr_mode_e                       mode;

  assign mode = chr_mode_e'(chr_mode);

  chr_bank_regs #(.BANK_W(BANK_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cpu_we),
    .addr   (cpu_addr),
    .wdata  (cpu_wdata),
    .bank_q (bank_q)
  );

  chr_latch_snoop u_snoop (
    .clk      (clk),
    .rst_n    (rst_n),
    .snoop_en (snoop_en),
    .ppu_rd   (ppu_rd),
    .ppu_addr (ppu_addr),
    .latch_lo (latch_lo),
    .latch_hi (latch_hi)
  );

  chr_outer_bank #(
    .BANK_W     (BANK_W),
    .OUTER_W    (OUTER_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_outer (
    .mode      (mode),
    .outer_off (outer_off),
    .outer_sel (outer_sel),
    .mask      (mask),
    .base      (base)
  );

  chr_addr_mux #(.BANK_W(BANK_W)) u_mux (
    .bank_q    (bank_q),
    .latch_lo  (latch_lo),
    .latch_hi  (latch_hi),
    .mode      (mode),
    .mask      (mask),
    .base      (base),
    .pat_addr  (ppu_addr[12:0]),
    .slot_idx  (slot_idx),
    .slot_bank (slot_bank),
    .rom_addr  (chr_rom_addr)
  );

  a_r10_full_register: assert property (@(posedge clk) disable iff (!rst_n)
    outer_off |-> slot_bank == bank_q[slot_idx]);

  a_r11_outer_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !outer_off |-> ((slot_bank & ~mask) == base) &&
                   ((slot_bank & mask) == (bank_q[slot_idx] & mask)));

endmodule

// File: tb/chr_latch_mapper_test.sv
module chr_latch_mapper_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [1:0]  chr_mode = 2'd3;
  logic        outer_off = 1'b1;
  logic [1:0]  outer_sel = '0;
  logic        snoop_en = 1'b1;
  logic        ppu_rd = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [28:0] chr_rom_addr;

  int checks = 0;
  int failures = 0;
  int mreg [8];
  int lat_lo = 0;
  int lat_hi = 4;

  always #10 clk = ~clk;

  chr_latch_mapper uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .chr_mode     (chr_mode),
    .outer_off    (outer_off),
    .outer_sel    (outer_sel),
    .snoop_en     (snoop_en),
    .ppu_rd       (ppu_rd),
    .ppu_addr     (ppu_addr),
    .chr_rom_addr (chr_rom_addr)
  );

  function automatic longint expect_addr(int m, int off, int sel, int a);
    int sz = 8192 >> m;
    int idx;
    longint bank;
    case (m)
      0: idx = 0;
      1: idx = (a >= 4096) ? lat_hi : lat_lo;
      2: idx = (a / 2048) * 2;
      default: idx = a / 1024;
    endcase
    bank = mreg[idx];
    if (off == 0) begin
      int lim = 32 << m;
      bank = (bank % lim) + sel * lim;
    end
    return bank * sz + (a % sz);
  endfunction

  task automatic check(longint got, longint exp, string req);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic probe(int m, int off, int sel, int a, string req);
    chr_mode = 2'(m); outer_off = off[0]; outer_sel = 2'(sel);
    ppu_addr = 14'(a);
    #1;
    check(longint'(chr_rom_addr), expect_addr(m, off, sel, a), req);
  endtask

  task automatic cpu_write(int addr, int data);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 16'(addr); cpu_wdata = 8'(data);
    @(negedge clk);
    cpu_we = 1'b0;
    if (addr / 4096 == 9)
      mreg[addr % 8] = (mreg[addr % 8] / 256) * 256 + data;
    else if (addr / 4096 == 10)
      mreg[addr % 8] = data * 256 + (mreg[addr % 8] % 256);
  endtask

  task automatic fetch(int a, bit rd);
    int row;
    @(negedge clk);
    ppu_rd = rd; ppu_addr = 14'(a);
    @(negedge clk);
    ppu_rd = 1'b0;
    row = a % 4096;
    if (rd && snoop_en && a < 8192) begin
      if (row >= 'hFD8 && row <= 'hFDF) begin
        if (a >= 4096) lat_hi = 4; else lat_lo = 0;
      end else if (row >= 'hFE8 && row <= 'hFEF) begin
        if (a >= 4096) lat_hi = 6; else lat_lo = 2;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: reset contents seen through 1K and latched 4K lookups
    for (int k = 0; k < 8; k++) probe(3, 1, 0, k * 1024 + 7, "R3 reset regs");
    probe(1, 1, 0, 'h0010, "R3 reset latch lo");
    probe(1, 1, 0, 'h1010, "R3 reset latch hi");

    // R1 / R2: byte writes, including aliased addresses
    cpu_write('h9003, 'h12);
    probe(3, 1, 0, 3 * 1024 + 5, "R1 low byte only");
    cpu_write('hAF0B, 'h34);
    probe(3, 1, 0, 3 * 1024 + 5, "R2 high byte aliased");
    cpu_write('h9FFB, 'h56);
    probe(3, 1, 0, 3 * 1024 + 9, "R1 low byte aliased");

    // R12: other pages ignored
    cpu_write('hB003, 'h00);
    cpu_write('h8003, 'h00);
    cpu_write('hC003, 'h00);
    probe(3, 1, 0, 3 * 1024 + 9, "R12 stray writes ignored");

    for (int i = 0; i < 8; i++) begin
      int v = (i * 'h2345 + 'h0F1E) % 65536;
      cpu_write('h9000 + i, v % 256);
      cpu_write('hA000 + i, v / 256);
    end
    probe(3, 1, 0, 2 * 1024, "R1 R2 full load");

    // R4 R5 R6 R7 R10 R11: sweep modes, outer settings, slots
    for (int m = 0; m < 4; m++)
      for (int off = 0; off < 2; off++)
        for (int sel = 0; sel < 4; sel++)
          for (int k = 0; k < 8; k++) begin
            string req;
            case (m)
              0: req = "R4 8K";
              1: req = "R7 4K";
              2: req = "R5 2K";
              default: req = "R6 1K";
            endcase
            req = {req, off ? " R10 plain" : " R11 outer"};
            probe(m, off, sel, k * 1024 + ((k * 37 + 5) % 1024), req);
            probe(m, off, sel, k * 1024 + 1023, req);
          end

    // R8: latch switching by marker fetches
    snoop_en = 1'b1;
    fetch('h0FE8, 1'b1);
    probe(1, 1, 0, 'h0123, "R8 lo to 2");
    fetch('h1FEC, 1'b1);
    probe(1, 1, 0, 'h1123, "R8 hi to 6");
    probe(1, 0, 2, 'h1123, "R8 R11 hi latched outer");
    fetch('h0FD0, 1'b1);
    fetch('h0FE0, 1'b1);
    fetch('h0FF0, 1'b1);
    fetch('h2FD8, 1'b1);
    fetch('h0FD8, 1'b0);
    probe(1, 1, 0, 'h0200, "R8 near misses keep lo");
    fetch('h0FDF, 1'b1);
    probe(1, 1, 0, 'h0200, "R8 lo to 0");
    fetch('h0FEF, 1'b1);
    probe(1, 1, 0, 'h0200, "R8 lo to 2 end row");

    // R9: latch follows in 1K mode, used once 4K is selected
    chr_mode = 2'd3;
    fetch('h1FD8, 1'b1);
    probe(1, 1, 0, 'h1777, "R9 hi switched while 1K");
    snoop_en = 1'b0;
    fetch('h0FD8, 1'b1);
    fetch('h1FE8, 1'b1);
    probe(1, 1, 0, 'h0777, "R9 strap off lo held");
    probe(1, 1, 0, 'h1777, "R9 strap off hi held");

    // R3 again: reset restores all state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) mreg[i] = 'hFFFF;
    lat_lo = 0; lat_hi = 4;
    probe(1, 1, 0, 'h0001, "R3 re-reset lo");
    probe(1, 1, 0, 'h1001, "R3 re-reset hi");
    probe(2, 1, 0, 'h1801, "R3 re-reset regs");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule